// File: doc/BRIEF.md
# Touchscreen Measurement Command Sequencer

This block runs a touch panel's measurement plan from a short list of command words that software loads through one register. Software first reads the command register, which empties the list. It then writes the command words one by one and closes the list with a write of zero. Each word names the panel pin to be sampled, the positive and negative references, and which pins are grounded or driven to supply for that conversion. Drivers usually load the commands in pairs, with the second channel of a pair first.

When the touch engine is enabled, the block steps through the list again and again. For each entry it drives the word on `pin_cmd` and lets the panel settle for a programmed number of 10 µs ticks. It then takes a programmed number of conversion ticks and keeps the converter value present on the last one. Results queue in a small FIFO that software drains through the touch data register, two results per read. At the end of each pass through the list a status flag is set and the interrupt output rises. The flag is cleared by writing a one to its bit.

Top module: `touch_cmd_seq`

## Requirements
- R1: After reset `touch_irq` is 0, `pin_cmd` is 0 and a read of the touch data register (0x18) returns 0.
- R2: A read of the command register (0x24) empties the list and disarms it. Nonzero writes to 0x24 append in order. A write of 0 arms the list, and later writes are ignored until the next clearing read. A list that has not been armed causes no conversions.
- R3: The list holds 8 entries. Nonzero writes beyond the eighth are ignored, so a pass runs exactly the first 8 entries.
- R4: Bit 2 of the engine register (0x00) enables the sequencer. While it is 0, `pin_cmd` stays 0 and no results are queued.
- R5: Two clock edges after the edge that sets the enable bit, `pin_cmd` shows the first list entry. The entries follow in load order and the list then wraps to the first entry again.
- R6: For each entry the block waits for the number of ticks in the wait register (0x14), then for the number of ticks in the repeat register (0x10), where 0 counts as 1. It queues the `adc_result` value present on the final tick. For a one-entry list the flag rises on tick number wait+repeat.
- R7: When a pass through the list ends, bit 2 of the status register (0x0C) is set and `touch_irq` follows it. Writing 1 to that bit clears it. Writing 0 has no effect.
- R8: A read of 0x18 returns the oldest result in bits [11:0] and the next one in bits [27:16], and removes both from the queue. If only one result is queued, bits [27:16] are 0. If the queue is empty the read returns 0. Read data is valid on the clock edge after the read request.
- R9: The result queue holds 8 entries. Results that arrive while it is full are dropped, and the earlier results are kept.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick_10us | input | 1 | One-cycle pacing tick |
| adc_result | input | 12 | Converter value for the current command |
| pin_cmd | output | 26 | Active command word, 0 when idle |
| touch_irq | output | 1 | Touch data flag |

## Verification
Read data appears one edge after the read strobe, so the bench samples `bus_rdata` on the falling edge that follows that rising edge. The first command word shows two edges after the enable write, and the bench checks `pin_cmd` on the falling edge after the second edge. Pacing is counted in ticks, not cycles. The bench counts the ticks it issues until the flag appears and expects wait+repeat. The ticks are spaced four cycles apart, so the one-cycle step from settling to conversion never hides a tick. The bench drives the converter input from the command word itself, which lets it predict every queued value and its order without looking inside the block.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam logic [7:0] A_ENGINE = 8'h00;
  localparam logic [7:0] A_STATUS = 8'h0C;
  localparam logic [7:0] A_REPEAT = 8'h10;
  localparam logic [7:0] A_WAIT   = 8'h14;
  localparam logic [7:0] A_TDATA  = 8'h18;
  localparam logic [7:0] A_CMD    = 8'h24;
  localparam int TOUCH_BIT = 2;
  localparam int HALF_W    = 16;

  typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_CONV} phase_t;

  // a repeat count of zero still takes one conversion
  function automatic int unsigned eff_reps(input int unsigned r);
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/tsq_cmd_list.sv
module tsq_cmd_list #(
  parameter int CMD_W = 26,
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [CMD_W-1:0] wdata,
  input  logic [IW-1:0]    rd_idx,
  output logic [CMD_W-1:0] entry,
  output logic [CW-1:0]    count,
  output logic             armed
);
  logic [CMD_W-1:0] mem [DEPTH];
  logic             append_ok;

  assign append_ok = wr && !armed && (wdata != '0) && (count < CW'(DEPTH));
  assign entry     = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (clr) begin
      count <= '0;
      armed <= 1'b0;
    end else if (wr && !armed && wdata == '0) begin
      armed <= 1'b1;
    end else if (append_ok) begin
      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (append_ok && !clr) mem[count[IW-1:0]] <= wdata;
  end

  assert_list_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !armed));
endmodule

// File: rtl/tsq_pacer.sv
module tsq_pacer
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RES_W = 12,
  parameter int TMR_W = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             armed,
  input  logic [CW-1:0]    count,
  input  logic             tick,
  input  logic [RES_W-1:0] adc,
  input  logic [TMR_W-1:0] wait_lim,
  input  logic [TMR_W-1:0] rep_lim,
  output logic [IW-1:0]    idx,
  output logic             active,
  output logic             push,
  output logic [RES_W-1:0] push_data,
  output logic             set_done
);
  phase_t          ph;
  logic [TMR_W-1:0] cnt;
  logic            run_ok, conv_last, entry_last;

  assign run_ok     = en && armed && (count != '0);
  assign conv_last  = (32'(cnt) + 1) >= eff_reps(32'(rep_lim));
  assign entry_last = (CW'(idx) + CW'(1)) == count;
  assign active     = (ph != PH_IDLE);
  assign push       = run_ok && (ph == PH_CONV) && tick && conv_last;
  assign push_data  = adc;
  assign set_done   = push && entry_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      idx <= '0;
      cnt <= '0;
    end else if (!run_ok) begin
      ph  <= PH_IDLE;
      idx <= '0;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          ph  <= PH_SETTLE;
          idx <= '0;
          cnt <= '0;
        end
        PH_SETTLE: begin
          if (cnt >= wait_lim) begin
            ph  <= PH_CONV;
            cnt <= '0;
          end else if (tick) begin
            cnt <= cnt + TMR_W'(1);
          end
        end
        default: begin
          if (tick) begin
            if (conv_last) begin
              cnt <= '0;
              ph  <= PH_SETTLE;
              idx <= entry_last ? '0 : idx + IW'(1);
            end else begin
              cnt <= cnt + TMR_W'(1);
            end
          end
        end
      endcase
    end
  end

  assert_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !active);
  assert_first_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> idx == '0);
endmodule

// File: rtl/tsq_result_fifo.sv
module tsq_result_fifo #(
  parameter int RES_W = 12,
  parameter int DEPTH = 8,   // power of two
  localparam int AW = $clog2(DEPTH),
  localparam int FCW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [RES_W-1:0] pdata,
  input  logic             pop2,
  output logic [RES_W-1:0] head_lo,
  output logic [RES_W-1:0] head_hi,
  output logic [FCW-1:0]   fill
);
  logic [RES_W-1:0] mem [DEPTH];
  logic [AW-1:0]    rptr, wptr;
  logic [FCW-1:0]   npop;
  logic             accept;

  assign accept  = push && (fill < FCW'(DEPTH));
  assign npop    = !pop2 ? '0 : (fill >= FCW'(2)) ? FCW'(2) : fill;
  assign head_lo = (fill >= FCW'(1)) ? mem[rptr] : '0;
  assign head_hi = (fill >= FCW'(2)) ? mem[rptr + AW'(1)] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      fill <= '0;
    end else begin
      rptr <= rptr + AW'(npop);
      if (accept) wptr <= wptr + AW'(1);
      fill <= fill - npop + FCW'(accept);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= pdata;
  end

  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FCW'(DEPTH));
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fill == FCW'(DEPTH) && !pop2) |=> fill == FCW'(DEPTH));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop2 && fill == '0 && !push) |=> fill == '0);
endmodule

// File: rtl/touch_cmd_seq.sv
module touch_cmd_seq
  import tsq_pkg::*;
#(
  parameter int CMD_W      = 26,
  parameter int RES_W      = 12,
  parameter int LIST_DEPTH = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int TMR_W      = 16,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_10us,
  input  logic [RES_W-1:0]  adc_result,
  output logic [CMD_W-1:0]  pin_cmd,
  output logic              touch_irq
);
  localparam int IW  = $clog2(LIST_DEPTH);
  localparam int CW  = $clog2(LIST_DEPTH + 1);
  localparam int FCW = $clog2(FIFO_DEPTH + 1);
  localparam int PAD = HALF_W - RES_W;

  logic              eng_en, status_touch;
  logic [TMR_W-1:0]  wait_lim, rep_lim;
  logic              list_clr, list_wr, armed;
  logic [CMD_W-1:0]  entry;
  logic [CW-1:0]     count;
  logic [IW-1:0]     idx;
  logic              active, push, set_done, fifo_pop;
  logic [RES_W-1:0]  push_data, head_lo, head_hi;
  logic [FCW-1:0]    fill;
  logic [DATA_W-1:0] rd_mux;
  logic [7:0]        addr8;
  logic              unused_bits;

  assign addr8       = 8'(bus_addr);
  assign unused_bits = ^bus_wdata;
  assign list_clr    = bus_rd && addr8 == A_CMD;
  assign list_wr     = bus_wr && addr8 == A_CMD;
  assign fifo_pop    = bus_rd && addr8 == A_TDATA;
  assign pin_cmd     = active ? entry : '0;
  assign touch_irq   = status_touch;

  tsq_cmd_list #(.CMD_W(CMD_W), .DEPTH(LIST_DEPTH)) list_i (
    .clk(clk), .rst_n(rst_n), .clr(list_clr), .wr(list_wr),
    .wdata(bus_wdata[CMD_W-1:0]), .rd_idx(idx), .entry(entry),
    .count(count), .armed(armed));

  tsq_pacer #(.DEPTH(LIST_DEPTH), .RES_W(RES_W), .TMR_W(TMR_W)) pacer_i (
    .clk(clk), .rst_n(rst_n), .en(eng_en), .armed(armed), .count(count),
    .tick(tick_10us), .adc(adc_result), .wait_lim(wait_lim),
    .rep_lim(rep_lim), .idx(idx), .active(active), .push(push),
    .push_data(push_data), .set_done(set_done));

  tsq_result_fifo #(.RES_W(RES_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pdata(push_data),
    .pop2(fifo_pop), .head_lo(head_lo), .head_hi(head_hi), .fill(fill));

  always_comb begin
    rd_mux = '0;
    case (addr8)
      A_ENGINE: rd_mux[TOUCH_BIT] = eng_en;
      A_STATUS: rd_mux[TOUCH_BIT] = status_touch;
      A_REPEAT: rd_mux = DATA_W'(rep_lim);
      A_WAIT:   rd_mux = DATA_W'(wait_lim);
      A_TDATA:  rd_mux = DATA_W'({{PAD{1'b0}}, head_hi, {PAD{1'b0}}, head_lo});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_en       <= 1'b0;
      status_touch <= 1'b0;
      wait_lim     <= '0;
      rep_lim      <= '0;
      bus_rdata    <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr && addr8 == A_ENGINE) eng_en <= bus_wdata[TOUCH_BIT];
      if (bus_wr && addr8 == A_WAIT)   wait_lim <= bus_wdata[TMR_W-1:0];
      if (bus_wr && addr8 == A_REPEAT) rep_lim  <= bus_wdata[TMR_W-1:0];
      if (set_done)
        status_touch <= 1'b1;
      else if (bus_wr && addr8 == A_STATUS && bus_wdata[TOUCH_BIT])
        status_touch <= 1'b0;
    end
  end

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(touch_irq) |-> $past(set_done));
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && fill == '0) |=> bus_rdata == '0);
endmodule

// File: tb/touch_cmd_seq_tb_top.sv
module touch_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_10us = 1'b0;
  logic [11:0] adc_result;
  logic [25:0] pin_cmd;
  logic        touch_irq;

  int checks = 0, errors = 0;
  int ticks = 0, cyc = 0;
  logic tick_on = 1'b0;
  logic [11:0] expq [16];

  localparam int NVEC = 4;
  localparam logic [25:0] VEC_W [NVEC][4] = '{
    '{26'h0118400, 26'h0248100, 26'h0000000, 26'h0000000},
    '{26'h0218080, 26'h0118200, 26'h0090400, 26'h0000000},
    '{26'h0848400, 26'h0000000, 26'h0000000, 26'h0000000},
    '{26'h0100100, 26'h0208400, 26'h03C0080, 26'h2018200}};
  localparam int VEC_N [NVEC] = '{2, 3, 1, 4};

  always #4 clk = ~clk;  // 125 MHz

  touch_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_10us(tick_10us), .adc_result(adc_result), .pin_cmd(pin_cmd),
    .touch_irq(touch_irq));

  // converter model: value derived from the active command
  assign adc_result = pin_cmd[19:8];

  function automatic logic [11:0] res_of(input logic [25:0] w);
    return w[19:8];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (tick_on && (cyc % 4 == 0)) begin
      tick_10us <= 1'b1;
      ticks++;
    end else begin
      tick_10us <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_ticks(input int n);
    int t0;
    t0 = ticks;
    tick_on = 1'b1;
    while (ticks - t0 < n) @(negedge clk);
    tick_on = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_irq(output int nt);
    int t0, guard;
    t0 = ticks; guard = 0;
    tick_on = 1'b1;
    while (!touch_irq && guard < 2000) begin @(negedge clk); guard++; end
    tick_on = 1'b0;
    nt = ticks - t0;
  endtask

  task automatic drain(input int n, input string tag);
    logic [31:0] d;
    for (int p = 0; p < n; p += 2) begin
      logic [11:0] hi;
      hi = (p + 1 < n) ? expq[p+1] : 12'h000;
      rd(8'h18, d);
      check(d == {4'h0, hi, 4'h0, expq[p]}, tag, d, {4'h0, hi, 4'h0, expq[p]});
    end
    rd(8'h18, d);
    check(d == 32'h0, {tag, " empty"}, d, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int nt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(touch_irq == 1'b0, "R1 irq", touch_irq, 0);
    check(pin_cmd == '0, "R1 pin_cmd", pin_cmd, 0);
    rd(8'h18, d);
    check(d == 32'h0, "R1 tdata", d, 0);

    wr(8'h14, 1); wr(8'h10, 1);
    // table of command lists: R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      rd(8'h24, d);
      for (int i = 0; i < VEC_N[v]; i++) begin
        wr(8'h24, {6'h0, VEC_W[v][i]});
        expq[i] = res_of(VEC_W[v][i]);
      end
      wr(8'h24, 0);
      wr(8'h0C, 32'h4);
      wr(8'h00, 32'h4);
      @(negedge clk);
      check(pin_cmd == VEC_W[v][0], "R5 first entry", pin_cmd, VEC_W[v][0]);
      wait_irq(nt);
      check(touch_irq == 1'b1, "R7 irq after set", touch_irq, 1);
      wr(8'h00, 0);
      drain(VEC_N[v], "R8 vector");
    end

    // R7 clear semantics
    wr(8'h0C, 32'h0);
    check(touch_irq == 1'b1, "R7 write 0 keeps flag", touch_irq, 1);
    rd(8'h0C, d);
    check(d[2] == 1'b1, "R7 status bit", d[2], 1);
    wr(8'h0C, 32'h4);
    check(touch_irq == 1'b0, "R7 write 1 clears", touch_irq, 0);

    // R4 disabled engine: nothing queued
    run_ticks(20);
    check(pin_cmd == '0, "R4 pin_cmd idle", pin_cmd, 0);
    rd(8'h18, d);
    check(d == 32'h0, "R4 no results", d, 0);

    // R2 unterminated list does not run
    rd(8'h24, d);
    wr(8'h24, 32'h0118400); wr(8'h24, 32'h0248100);
    wr(8'h00, 32'h4);
    run_ticks(20);
    check(pin_cmd == '0, "R2 unarmed idle", pin_cmd, 0);
    rd(8'h18, d);
    check(d == 32'h0, "R2 unarmed no results", d, 0);
    check(touch_irq == 1'b0, "R2 unarmed no flag", touch_irq, 0);
    wr(8'h00, 0);

    // R3 nine writes, eight kept
    rd(8'h24, d);
    for (int i = 0; i < 9; i++) begin
      logic [25:0] w;
      w = 26'h0100080 + 26'(i) * 26'h0001100;
      wr(8'h24, {6'h0, w});
      if (i < 8) expq[i] = res_of(w);
    end
    wr(8'h24, 0);
    wr(8'h00, 32'h4);
    wait_irq(nt);
    wr(8'h00, 0);
    drain(8, "R3 eight entries");
    wr(8'h0C, 32'h4);

    // R6 pacing: wait 3, repeat 2 -> 5 ticks
    rd(8'h24, d);
    wr(8'h24, 32'h0848400); wr(8'h24, 0);
    wr(8'h14, 3); wr(8'h10, 2);
    wr(8'h00, 32'h4);
    repeat (3) @(negedge clk);
    wait_irq(nt);
    check(nt == 5, "R6 ticks wait3 rep2", nt, 5);
    wr(8'h00, 0); wr(8'h0C, 32'h4);
    rd(8'h18, d);
    check(d == {20'h0, res_of(26'h0848400)}, "R6 sample value", d, res_of(26'h0848400));
    // R6 zeros: one tick
    wr(8'h14, 0); wr(8'h10, 0);
    wr(8'h00, 32'h4);
    repeat (3) @(negedge clk);
    wait_irq(nt);
    check(nt == 1, "R6 ticks wait0 rep0", nt, 1);
    wr(8'h00, 0); wr(8'h0C, 32'h4);
    rd(8'h18, d);

    // R9 full queue drops newer results: 5 entries, two passes
    rd(8'h24, d);
    for (int i = 0; i < 5; i++) begin
      logic [25:0] w;
      w = 26'h0200100 + 26'(i) * 26'h0002200;
      wr(8'h24, {6'h0, w});
      expq[i] = res_of(w);
      if (i < 3) expq[i+5] = res_of(w);
    end
    wr(8'h24, 0);
    wr(8'h14, 1); wr(8'h10, 1);
    wr(8'h00, 32'h4);
    repeat (3) @(negedge clk);
    run_ticks(26);
    wr(8'h00, 0);
    drain(8, "R9 full drop");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule